// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Strobe Bus

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It owns the result register, whose value drives an external DAC, and it reads a single comparator bit back every clock. A host talks to it over a processor-style strobe interface with four signals:

- an active-low chip select,
- an active-low write strobe,
- an active-low read strobe,
- an active-low interrupt.

While chip select and write are both low, the register is held cleared. When the write condition ends, a conversion begins. The controller then resolves one bit per clock, from the most significant bit to the least, and pulls the interrupt low when it has finished. The host reads the result by pulling chip select and read low. This enables the data bus and also releases the interrupt.

The sequencer has four states:

- `ST_IDLE` waits with the last result held.
- `ST_CLEAR` holds the register at zero while the write condition lasts.
- `ST_TRIAL` resolves one bit per cycle.
- `ST_DONE` flags completion for one cycle.

It makes these transitions:

- Any state goes to `ST_CLEAR` while the write condition is seen (write-hold).
- `ST_CLEAR` goes to `ST_TRIAL` when the write condition ends (write-release).
- `ST_TRIAL` stays in `ST_TRIAL` while bits remain (next-bit).
- `ST_TRIAL` goes to `ST_DONE` after bit 0 (last-bit).
- `ST_DONE` goes to `ST_IDLE` unconditionally (flag).

Top module: `sar_strobe_adc`

## Requirements
- R1: After reset, `dac_code` is 0x00, `intr_n` is high and `data_oe` is low.
- R2: While chip select and write are both low, the result register is forced to 0x00 and `intr_n` is high. This takes effect on the third rising clock edge after the strobes fall, because of two synchroniser stages and one state register.
- R3: A conversion begins when the write condition ends. Three clock edges after the release, `dac_code` is 0x80: bit 7 is set and all lower bits are clear.
- R4: During each trial, the bit under test stays 1 when `cmp_hi` is high, which means the input is above the DAC level. Otherwise the bit is cleared. The next lower bit is then set to 1. Bits are tried from 7 down to 0, so the final code is the binary value of the input, where 0x00 is zero and 0xFF is 255/256 of the reference.
- R5: `intr_n` falls exactly 12 clock edges after the write release: 2 synchroniser edges, 1 launch edge, 8 trial edges and 1 flag edge.
- R6: `intr_n` stays high for the whole conversion.
- R7: `data_oe` is high, and `data_bus` carries the result, only while both `cs_n` and `rd_n` are low. Otherwise the bus is high-impedance.
- R8: The start of a read cycle returns `intr_n` high on the third clock edge after the strobes fall.
- R9: A write during a conversion aborts it. The register is cleared, and the conversion that follows the new release yields the new input's code without `intr_n` ever falling.
- R10: A low write strobe while `cs_n` is high has no effect. No conversion starts, and the result and `intr_n` keep their values.
- R11: Outside a write or a conversion, the result register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write / start strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_hi | input | 1 | Comparator: high when the analog input exceeds the DAC level |
| dac_code | output | 8 | Result register, drives the external DAC |
| intr_n | output | 1 | Conversion-done interrupt, active low |
| data_oe | output | 1 | Data bus output enable |
| data_bus | output | 8 | Result on the data bus, high-impedance unless enabled |

## Verification
The checker examines every cycle. It checks these properties of the sequencer:

- The register is zero while the write condition holds.
- During a trial, exactly the bit under test is the lowest set bit.
- Trials advance without stalling.
- The interrupt falls only out of the flag state and is high while the register is cleared.
- The result holds in idle.

Only the bench scenarios can show the following. The bench models the analog input at half-LSB positions:

- the end-to-end code produced for different inputs,
- the exact 12-edge latency,
- the abort-and-restart behaviour,
- the read that releases the interrupt,
- that a write without chip select is ignored.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_TRIAL = 2'd2,
        ST_DONE  = 2'd3
    } sar_state_e;

endpackage

// File: rtl/adc_strobe_sync.sv
// Brings the host strobes into the clock domain and decodes them into
// write-hold, write-release and read-start events.
module adc_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_hold,
    output logic wr_release,
    output logic rd_start
);

    localparam int NSIG = 3;

    logic [NSIG-1:0] chain [STAGES];
    logic            wr_hold_q;
    logic            rd_act_q;
    logic            rd_act;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '1;
                end else if (s == 0) begin
                    chain[s] <= {rd_n, wr_n, cs_n};
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign wr_hold = ~chain[STAGES-1][0] & ~chain[STAGES-1][1];
    assign rd_act  = ~chain[STAGES-1][0] & ~chain[STAGES-1][2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_hold_q <= 1'b0;
            rd_act_q  <= 1'b0;
        end else begin
            wr_hold_q <= wr_hold;
            rd_act_q  <= rd_act;
        end
    end

    assign wr_release = wr_hold_q & ~wr_hold;
    assign rd_start   = rd_act & ~rd_act_q;

endmodule

// File: rtl/adc_sar_seq.sv
// Bit-trial sequencer and result register.
module adc_sar_seq
    import adc_sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_hold,
    input  logic                      wr_release,
    input  logic                      cmp_hi,
    output logic [WIDTH-1:0]          code,
    output logic [$clog2(WIDTH)-1:0]  trial_bit,
    output sar_state_e                state,
    output logic                      done
);

    localparam int IDXW = $clog2(WIDTH);
    localparam logic [IDXW-1:0] TOP_BIT = IDXW'(WIDTH - 1);

    sar_state_e      state_nxt;
    logic [WIDTH-1:0] trial_nxt;

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (wr_hold) begin
            state_nxt = ST_CLEAR;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_CLEAR: state_nxt = wr_release ? ST_TRIAL : ST_CLEAR;
                ST_TRIAL: state_nxt = (trial_bit == '0) ? ST_DONE : ST_TRIAL;
                ST_DONE:  state_nxt = ST_IDLE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // resolved value for the bit under test, next bit armed
    always_comb begin
        trial_nxt = code;
        trial_nxt[trial_bit] = cmp_hi;
        if (trial_bit != '0) begin
            trial_nxt[trial_bit - 1'b1] = 1'b1;
        end
    end

    // outputs: result register and bit pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code      <= '0;
            trial_bit <= TOP_BIT;
        end else if (wr_hold) begin
            code      <= '0;
            trial_bit <= TOP_BIT;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    if (wr_release) begin
                        code          <= '0;
                        code[TOP_BIT] <= 1'b1;
                        trial_bit     <= TOP_BIT;
                    end
                end
                ST_TRIAL: begin
                    code <= trial_nxt;
                    if (trial_bit != '0) begin
                        trial_bit <= trial_bit - 1'b1;
                    end
                end
                ST_IDLE, ST_DONE: begin
                    code <= code;
                end
                default: code <= code;
            endcase
        end
    end

    assign done = (state == ST_DONE);

endmodule

// File: rtl/adc_irq_flag.sv
// Active-low completion interrupt.
module adc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_set,
    input  logic done,
    input  logic rd_start,
    output logic intr_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_n <= 1'b1;
        end else if (busy_set) begin
            intr_n <= 1'b1;
        end else if (done) begin
            intr_n <= 1'b0;
        end else if (rd_start) begin
            intr_n <= 1'b1;
        end
    end

endmodule

// File: rtl/sar_strobe_adc.sv
module sar_strobe_adc
    import adc_sar_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] dac_code,
    output logic             intr_n,
    output logic             data_oe,
    output logic [WIDTH-1:0] data_bus
);

    localparam int IDXW = $clog2(WIDTH);

    logic            wr_hold;
    logic            wr_release;
    logic            rd_start;
    logic            seq_done;
    logic [IDXW-1:0] trial_bit;
    sar_state_e      seq_state;

    adc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .wr_hold    (wr_hold),
        .wr_release (wr_release),
        .rd_start   (rd_start)
    );

    adc_sar_seq #(.WIDTH(WIDTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hold    (wr_hold),
        .wr_release (wr_release),
        .cmp_hi     (cmp_hi),
        .code       (dac_code),
        .trial_bit  (trial_bit),
        .state      (seq_state),
        .done       (seq_done)
    );

    adc_irq_flag u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_set (wr_hold),
        .done     (seq_done),
        .rd_start (rd_start),
        .intr_n   (intr_n)
    );

    // bus enable follows the raw strobes, like a pad-level output gate
    assign data_oe  = ~cs_n & ~rd_n;
    assign data_bus = data_oe ? dac_code : 'z;

endmodule

// File: rtl/adc_sar_checker.sv
module adc_sar_checker
    import adc_sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIDTH-1:0]         dac_code,
    input  logic                     intr_n,
    input  logic                     wr_hold,
    input  logic [$clog2(WIDTH)-1:0] trial_bit,
    input  sar_state_e               seq_state
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R2: cleared register and busy interrupt while the write condition holds
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_CLEAR) |-> (dac_code == '0 && intr_n));

    // R4: bit under test is set, everything below it is clear
    p_trial_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_TRIAL) |->
            ((dac_code & ((ONE << trial_bit) | ((ONE << trial_bit) - ONE))) == (ONE << trial_bit)));

    // R5: trials advance every cycle without stalling
    p_trial_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_TRIAL && trial_bit != '0 && !wr_hold) |=>
            (seq_state == ST_TRIAL && trial_bit == $past(trial_bit) - 1'b1));

    // R6: interrupt only falls out of the flag state
    p_irq_from_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_n) |-> ($past(seq_state) == ST_DONE));

    // R11: result holds while idle
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE) |=> ($stable(dac_code) || seq_state == ST_CLEAR));

endmodule

bind sar_strobe_adc adc_sar_checker #(.WIDTH(WIDTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dac_code  (dac_code),
    .intr_n    (intr_n),
    .wr_hold   (wr_hold),
    .trial_bit (trial_bit),
    .seq_state (seq_state)
);

// File: tb/test_sar_strobe_adc.sv
`timescale 1ns/1ps
module test_sar_strobe_adc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       cmp_hi;
    logic [7:0] dac_code;
    logic       intr_n;
    logic       data_oe;
    wire  [7:0] data_bus;
    logic [8:0] vin2 = 9'd1;   // analog input in half-LSB units
    int         n_run = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    // comparator model: input above DAC level
    assign cmp_hi = (vin2 > {dac_code, 1'b0});

    sar_strobe_adc i_sar_strobe_adc (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .intr_n(intr_n),
        .data_oe(data_oe), .data_bus(data_bus)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R2: hold a write, check the clear
    task automatic write_hold();
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0;
        edges(3);
        chk(dac_code == 8'h00, "R2 clear", dac_code, 0);
        chk(intr_n == 1'b1, "R2 busy", intr_n, 1);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    // R3 R4 R5 R6: full conversion for a code
    task automatic convert(input logic [7:0] val);
        bit hi_ok = 1;
        vin2 = {val, 1'b1};
        write_hold();
        edges(3);
        chk(dac_code == 8'h80, "R3 first trial", dac_code, 8'h80);
        for (int i = 0; i < 8; i++) begin
            if (intr_n !== 1'b1) hi_ok = 0;
            edges(1);
        end
        chk(hi_ok && intr_n == 1'b1, "R6 busy during conversion", intr_n, 1);
        edges(1);
        chk(intr_n == 1'b0, "R5 done at edge 12", intr_n, 0);
        chk(dac_code == val, "R4 result", dac_code, val);
    endtask

    // R7 R8: read cycle
    task automatic read_result(input logic [7:0] val);
        chk(data_oe == 1'b0, "R7 bus off before read", data_oe, 0);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk(data_oe == 1'b1, "R7 bus on", data_oe, 1);
        chk(data_bus == val, "R7 bus value", data_bus, val);
        edges(3);
        chk(intr_n == 1'b1, "R8 read releases irq", intr_n, 1);
        rd_n = 1'b1;
        #1;
        chk(data_oe == 1'b0, "R7 off with rd high", data_oe, 0);
        cs_n = 1'b1;
        edges(3);
    endtask

    // R9: abort mid-conversion
    task automatic abort_restart();
        bit low_seen = 0;
        vin2 = {8'h3C, 1'b1};
        write_hold();
        edges(6);
        vin2 = {8'hC5, 1'b1};
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (intr_n == 1'b0) low_seen = 1;
            edges(1);
        end
        chk(dac_code == 8'h00, "R9 abort clears", dac_code, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        for (int i = 0; i < 11; i++) begin
            if (intr_n == 1'b0) low_seen = 1;
            edges(1);
        end
        chk(!low_seen, "R9 no early done", low_seen, 0);
        edges(1);
        chk(intr_n == 1'b0 && dac_code == 8'hC5, "R9 restart result", dac_code, 8'hC5);
    endtask

    // R10 R11: write without chip select
    task automatic ignored_write(input logic [7:0] held);
        vin2 = 9'd3;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0;
        edges(4);
        wr_n = 1'b1;
        edges(16);
        chk(dac_code == held, "R10 R11 result kept", dac_code, held);
        chk(intr_n == 1'b1, "R10 no conversion", intr_n, 1);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        edges(2);
        rst_n = 1'b1;
        edges(1);
        chk(dac_code == 8'h00, "R1 reset code", dac_code, 0);
        chk(intr_n == 1'b1, "R1 reset irq", intr_n, 1);
        chk(data_oe == 1'b0, "R1 reset oe", data_oe, 0);
        convert(8'hA7);  read_result(8'hA7);
        convert(8'h00);  read_result(8'h00);
        convert(8'hFF);  read_result(8'hFF);
        convert(8'h80);  read_result(8'h80);
        convert(8'h5A);  read_result(8'h5A);
        abort_restart(); read_result(8'hC5);
        ignored_write(8'hC5);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule